// File: doc/BRIEF.md
# Nibble-Bus Decimal-Addressed Opcode ROM

This block is a read-only store of 15,000 eight-bit opcodes. It answers a host over a shared 4-bit bus that the host selects with an active-high select line. The block keeps a five-digit packed decimal pointer. The host can load that pointer, read it back, fetch the byte it addresses, or fetch a burst of eight consecutive bytes. Every value crosses the bus one nibble at a time. Each nibble occupies a slot of four clock cycles. The first slot after select rises carries a command nibble.

The store holds no loaded contents. Each byte is computed from its binary index, so no memory image is needed. The pointer always stays in decimal form. It is converted to binary only to form the byte index. The pointer steps with decimal carry and folds back to zero after the last valid address. A selection may hold any number of back-to-back commands. Dropping select ends the current command at once.

The bus is split into an input nibble, an output nibble and an output enable. A pad ring or the host model combines these three into a shared line.

Top module: `nibble_rom_slave`

## Requirements
- R1: While `sel` is low, `bus_oe` is low and nibbles on `bus_i` have no effect on the pointer.
- R2: Command nibble 0x0, and any nibble other than 0x9, 0xA, 0xB and 0xC, leaves the pointer unchanged and drives nothing. The next slot is again a command slot.
- R3: Command 0x9 takes the next five host nibbles as the pointer's decimal digits, least significant digit first. The pointer takes the new value after the fifth digit.
- R4: Command 0xA drives the pointer's five decimal digits, least significant first, in the next five slots, with `bus_oe` high in those slots.
- R5: Command 0xB drives the addressed byte's low nibble in the next slot and its high nibble in the slot after. The pointer then advances by one.
- R6: Command 0xC drives sixteen nibbles in the next sixteen slots. These are the bytes at pointer, pointer+1, …, pointer+7, low nibble first in each byte. The pointer then advances by eight.
- R7: Every pointer step adds one with decimal carry. Address 14999 and address 99999 both step to 00000.
- R8: The byte at a decimal address a below 15000 equals (a mod 256) XOR 0x5A. At any address of 15000 or above, both nibbles read 0xF.
- R9: A slot lasts four clock cycles, counted from the first rising edge with `sel` high. The command is taken at the fourth edge, and read data is driven from the cycle after that edge.
- R10: If `sel` falls before a command's last slot, the pointer keeps the value it had before that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; pointer returns to 00000 |
| sel | input | 1 | Active-high select |
| bus_i | input | 4 | Nibble driven by the host |
| bus_o | output | 4 | Nibble driven by the block (0 when not driving) |
| bus_oe | output | 1 | High while the block drives the bus |

## Verification
Suppose the pointer's carry chain goes wrong. The digits read back after a step then show it, within the same selection that reads the pointer. In a burst, the error also shows as wrong data in the very next byte. If the slot counter or command sequencer slips, the bus enable moves a whole slot early or late, or never rises. The bench sees this within one selection. A wrong range or content function appears in the first byte fetched from the affected address. A lost abort appears as a changed pointer at the next pointer read.

// File: rtl/nrom_pkg.sv
package nrom_pkg;
  localparam int NIB_W  = 4;
  localparam int DIGITS = 5;
  localparam int PTR_W  = NIB_W * DIGITS;

  typedef logic [PTR_W-1:0] bcd_ptr_t;
  typedef enum logic [1:0] {SQ_CMD, SQ_LOAD, SQ_RADR, SQ_RDAT} sq_state_t;

  localparam logic [NIB_W-1:0] OP_NOP  = 4'h0;
  localparam logic [NIB_W-1:0] OP_LOAD = 4'h9;
  localparam logic [NIB_W-1:0] OP_RADR = 4'hA;
  localparam logic [NIB_W-1:0] OP_RD1  = 4'hB;
  localparam logic [NIB_W-1:0] OP_RD8  = 4'hC;

  // packed decimal to binary, most significant digit first
  function automatic int unsigned bcd_to_bin(bcd_ptr_t p);
    int unsigned acc = 0;
    for (int d = DIGITS - 1; d >= 0; d--)
      acc = acc * 10 + 32'(p[d*NIB_W +: NIB_W]);
    return acc;
  endfunction

  function automatic bcd_ptr_t bin_to_bcd(int unsigned v);
    bcd_ptr_t r = '0;
    int unsigned t = v;
    for (int d = 0; d < DIGITS; d++) begin
      r[d*NIB_W +: NIB_W] = NIB_W'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // one decimal step; the last valid address folds to zero
  function automatic bcd_ptr_t bcd_step(bcd_ptr_t p, bcd_ptr_t last);
    bcd_ptr_t r = '0;
    logic carry = 1'b1;
    logic [NIB_W-1:0] dig;
    if (p == last) return '0;
    for (int d = 0; d < DIGITS; d++) begin
      dig = p[d*NIB_W +: NIB_W];
      if (carry && dig >= 4'd9) begin
        r[d*NIB_W +: NIB_W] = '0;
      end else if (carry) begin
        r[d*NIB_W +: NIB_W] = dig + 4'd1;
        carry = 1'b0;
      end else begin
        r[d*NIB_W +: NIB_W] = dig;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] rom_byte(int unsigned idx, int unsigned depth,
                                          logic [7:0] key);
    if (idx < depth) return 8'(idx) ^ key;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/nrom_slot_timer.sv
module nrom_slot_timer #(
  parameter int STATES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic slot_end
);
  localparam int PH_W = (STATES > 1) ? $clog2(STATES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STATES - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase <= '0;
    else if (!sel)            phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  assign slot_end = sel && (phase == PH_LAST);
endmodule

// File: rtl/nrom_pointer.sv
module nrom_pointer
  import nrom_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  bcd_ptr_t nxt,
  output bcd_ptr_t ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr <= '0;
    else if (wr) ptr <= nxt;
  end
endmodule

// File: rtl/nrom_sequencer.sv
module nrom_sequencer
  import nrom_pkg::*;
#(
  parameter int       BURST_BYTES = 8,
  parameter int       CNT_W       = 4,
  parameter bcd_ptr_t LAST_BCD    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             slot_end,
  input  logic [NIB_W-1:0] bus_i,
  input  bcd_ptr_t         ptr,
  output sq_state_t        state,
  output logic [CNT_W-1:0] cnt,
  output bcd_ptr_t         cursor,
  output logic             ptr_wr,
  output bcd_ptr_t         ptr_nxt
);
  localparam logic [CNT_W-1:0] DIG_LAST   = CNT_W'(DIGITS - 1);
  localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(2 * BURST_BYTES - 1);
  localparam int               SH_W       = PTR_W - NIB_W;

  logic [CNT_W-1:0] last_cnt;
  logic [SH_W-1:0]  shadow;
  logic             load_done, read_done;

  assign load_done = slot_end && (state == SQ_LOAD) && (cnt == DIG_LAST);
  assign read_done = slot_end && (state == SQ_RDAT) && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_CMD;
      cnt      <= '0;
      last_cnt <= '0;
      cursor   <= '0;
      shadow   <= '0;
    end else if (!sel) begin
      state <= SQ_CMD;
      cnt   <= '0;
    end else if (slot_end) begin
      case (state)
        SQ_CMD: begin
          cnt    <= '0;
          cursor <= ptr;
          case (bus_i)
            OP_LOAD: state <= SQ_LOAD;
            OP_RADR: state <= SQ_RADR;
            OP_RD1: begin
              state    <= SQ_RDAT;
              last_cnt <= CNT_W'(1);
            end
            OP_RD8: begin
              state    <= SQ_RDAT;
              last_cnt <= BURST_LAST;
            end
            default: state <= SQ_CMD;
          endcase
        end
        SQ_LOAD: begin
          if (cnt == DIG_LAST) begin
            state <= SQ_CMD;
          end else begin
            shadow[int'(cnt)*NIB_W +: NIB_W] <= bus_i;
            cnt <= cnt + 1'b1;
          end
        end
        SQ_RADR: begin
          if (cnt == DIG_LAST) state <= SQ_CMD;
          else                 cnt   <= cnt + 1'b1;
        end
        default: begin
          if (cnt[0]) cursor <= bcd_step(cursor, LAST_BCD);
          if (cnt == last_cnt) state <= SQ_CMD;
          else                 cnt   <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ptr_wr  = sel && (load_done || read_done);
    ptr_nxt = (state == SQ_LOAD) ? {bus_i, shadow} : bcd_step(cursor, LAST_BCD);
  end
endmodule

// File: rtl/nibble_rom_slave.sv
module nibble_rom_slave
  import nrom_pkg::*;
#(
  parameter int         ROM_BYTES       = 15000,
  parameter int         BURST_BYTES     = 8,
  parameter int         STATES_PER_XFER = 4,
  parameter logic [7:0] FILL_KEY        = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [3:0] bus_i,
  output logic [3:0] bus_o,
  output logic       bus_oe
);
  localparam int       SPAN      = (2 * BURST_BYTES > DIGITS) ? 2 * BURST_BYTES : DIGITS;
  localparam int       CNT_W     = $clog2(SPAN);
  localparam bcd_ptr_t LAST_BCD  = bin_to_bcd(ROM_BYTES - 1);

  // named internal events, observed by the bound checker
  logic             slot_end;
  logic             ptr_wr;
  bcd_ptr_t         ptr_q, ptr_nxt, cursor;
  sq_state_t        sq_state;
  logic [CNT_W-1:0] sq_cnt;
  logic             rd_data_mode;
  logic [7:0]       cur_byte;

  nrom_slot_timer #(.STATES(STATES_PER_XFER)) u_timer (
    .clk(clk), .rst_n(rst_n), .sel(sel), .slot_end(slot_end)
  );

  nrom_pointer u_ptr (
    .clk(clk), .rst_n(rst_n), .wr(ptr_wr), .nxt(ptr_nxt), .ptr(ptr_q)
  );

  nrom_sequencer #(
    .BURST_BYTES(BURST_BYTES), .CNT_W(CNT_W), .LAST_BCD(LAST_BCD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sel(sel), .slot_end(slot_end), .bus_i(bus_i),
    .ptr(ptr_q), .state(sq_state), .cnt(sq_cnt), .cursor(cursor),
    .ptr_wr(ptr_wr), .ptr_nxt(ptr_nxt)
  );

  assign rd_data_mode = (sq_state == SQ_RDAT);
  assign cur_byte     = rom_byte(bcd_to_bin(cursor), ROM_BYTES, FILL_KEY);

  always_comb begin
    bus_o  = '0;
    bus_oe = 1'b0;
    if (sel) begin
      case (sq_state)
        SQ_RADR: begin
          bus_oe = 1'b1;
          bus_o  = ptr_q[int'(sq_cnt)*NIB_W +: NIB_W];
        end
        SQ_RDAT: begin
          bus_oe = 1'b1;
          bus_o  = sq_cnt[0] ? cur_byte[7:4] : cur_byte[3:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nrom_checker.sv
module nrom_checker
  import nrom_pkg::*;
#(
  parameter int ROM_BYTES = 15000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic [3:0] bus_o,
  input logic       bus_oe,
  input logic       slot_end,
  input logic       ptr_wr,
  input bcd_ptr_t   ptr_q,
  input bcd_ptr_t   cursor,
  input logic       rd_data_mode
);
  AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !bus_oe); // R1

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr |=> $stable(ptr_q)); // R10

  AST_SLOT_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> ($past(sel, 1) && $past(sel, 2) && $past(sel, 3))); // R9

  AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !slot_end); // R9

  AST_RANGE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && rd_data_mode && (bcd_to_bin(cursor) >= ROM_BYTES)) |-> (bus_o == 4'hF)); // R8
endmodule

bind nibble_rom_slave nrom_checker #(.ROM_BYTES(ROM_BYTES)) u_nrom_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .bus_o(bus_o), .bus_oe(bus_oe),
  .slot_end(slot_end), .ptr_wr(ptr_wr), .ptr_q(ptr_q), .cursor(cursor),
  .rd_data_mode(rd_data_mode)
);

// File: tb/test_nibble_rom_slave.sv
module test_nibble_rom_slave;
  localparam int STATES = 4;

  logic       clk = 1'b0;
  logic       rst_n, sel;
  logic [3:0] bus_i;
  logic [3:0] bus_o;
  logic       bus_oe;

  int checks = 0;
  int errors = 0;
  int model_ptr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibble_rom_slave i_nibble_rom_slave (
    .clk(clk), .rst_n(rst_n), .sel(sel), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe)
  );

  function automatic int ref_inc(int a);
    if (a == 14999 || a == 99999) return 0;
    return a + 1;
  endfunction

  function automatic int ref_byte(int a);
    if (a < 15000) return (a % 256) ^ 'h5A;
    return 'hFF;
  endfunction

  function automatic int digit_of(int a, int d);
    int t = a;
    for (int k = 0; k < d; k++) t = t / 10;
    return t % 10;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one slot: present d, sample outputs just after the slot starts
  task automatic xfer(input logic [3:0] d, output logic [3:0] q, output logic oe);
    bus_i = d;
    #1;
    q  = bus_o;
    oe = bus_oe;
    repeat (STATES) @(negedge clk);
  endtask

  task automatic end_tx();
    sel   = 1'b0;
    bus_i = 4'h0;
    @(negedge clk);
  endtask

  task automatic do_load(int a);
    logic [3:0] q; logic oe;
    sel = 1'b1;
    xfer(4'h9, q, oe);
    for (int d = 0; d < 5; d++) xfer(4'(digit_of(a, d)), q, oe);
    end_tx();
    model_ptr = a;
  endtask

  task automatic read_addr(string req);
    logic [3:0] q; logic oe; int val; int scale; bit all_oe;
    val = 0; scale = 1; all_oe = 1'b1;
    sel = 1'b1;
    xfer(4'hA, q, oe);
    for (int d = 0; d < 5; d++) begin
      xfer(4'h0, q, oe);
      all_oe &= oe;
      val += int'(q) * scale;
      scale *= 10;
    end
    end_tx();
    check(all_oe, req, "enable during pointer read", int'(all_oe), 1);
    check(val == model_ptr, req, "pointer digits", val, model_ptr);
  endtask

  task automatic read2(string req);
    logic [3:0] lo, hi; logic oe0, oe1; int b;
    sel = 1'b1;
    xfer(4'hB, lo, oe0);
    xfer(4'h0, lo, oe0);
    xfer(4'h0, hi, oe1);
    end_tx();
    b = {24'd0, hi, lo};
    check(oe0 && oe1 && b == ref_byte(model_ptr), req, "single byte", b, ref_byte(model_ptr));
    model_ptr = ref_inc(model_ptr);
  endtask

  task automatic read16(string req);
    logic [3:0] lo, hi; logic oe0, oe1; int b; int a;
    a = model_ptr;
    sel = 1'b1;
    xfer(4'hC, lo, oe0);
    for (int k = 0; k < 8; k++) begin
      xfer(4'h0, lo, oe0);
      xfer(4'h0, hi, oe1);
      b = {24'd0, hi, lo};
      check(oe0 && oe1 && b == ref_byte(a), req, "burst byte", b, ref_byte(a));
      a = ref_inc(a);
    end
    end_tx();
    model_ptr = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] q; logic oe; bit quiet;
    rst_n = 1'b0; sel = 1'b0; bus_i = 4'h0;
    repeat (3) @(negedge clk);
    check(bus_oe == 1'b0, "R1", "enable in reset", int'(bus_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: command taken at the fourth edge; pointer read starts driving after it
    sel = 1'b1; bus_i = 4'hA;
    quiet = 1'b1;
    for (int i = 0; i < STATES; i++) begin
      #1; quiet &= !bus_oe;
      @(negedge clk);
    end
    check(quiet, "R9", "no drive during command slot", int'(quiet), 1);
    #1;
    check(bus_oe == 1'b1, "R9", "drive after command slot", int'(bus_oe), 1);
    check(bus_o == 4'h0, "R4", "reset pointer digit", int'(bus_o), 0);
    @(negedge clk);
    end_tx();
    read_addr("R4");

    // R3/R4 pointer load and readback
    do_load(12345); read_addr("R3");
    do_load(14999); read_addr("R3");
    do_load(7);     read_addr("R4");
    do_load(10000); read_addr("R4");
    do_load(99941); read_addr("R3");

    // R5/R8 single-byte sweep
    do_load(0);
    for (int i = 0; i < 300; i++) read2("R5");
    read_addr("R5");

    // R6/R7/R8 burst sweep across the top of the range
    do_load(13800);
    for (int i = 0; i < 160; i++) read16("R6");
    read_addr("R7");

    // R7/R8 outside the range
    do_load(99998); read2("R8"); read2("R8"); read_addr("R7");
    do_load(15000); read2("R8"); read_addr("R7");
    do_load(14996); read16("R7"); read_addr("R7");

    // R2 idle and unknown commands
    do_load(4321);
    sel = 1'b1;
    xfer(4'h0, q, oe);
    xfer(4'h5, q, oe);
    check(!oe, "R2", "enable after idle command", int'(oe), 0);
    xfer(4'hF, q, oe);
    check(!oe, "R2", "enable after unknown command", int'(oe), 0);
    xfer(4'h0, q, oe);
    check(!oe, "R2", "enable after unknown command", int'(oe), 0);
    end_tx();
    read_addr("R2");

    // R1 deselected bus traffic
    sel = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      bus_i = (i % 3 == 0) ? 4'h9 : 4'(i % 10);
      #1; quiet &= !bus_oe;
      @(negedge clk);
    end
    check(quiet, "R1", "enable while deselected", int'(quiet), 1);
    read_addr("R1");

    // R10 aborted load and aborted burst
    sel = 1'b1;
    xfer(4'h9, q, oe);
    xfer(4'h1, q, oe); xfer(4'h2, q, oe); xfer(4'h3, q, oe);
    end_tx();
    read_addr("R10");
    sel = 1'b1;
    xfer(4'hC, q, oe);
    for (int i = 0; i < 6; i++) xfer(4'h0, q, oe);
    end_tx();
    read_addr("R10");
    read2("R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule